// File: doc/BRIEF.md
# Cartridge Bank Mapper Register Decoder

This block sits between a console CPU and PPU and the cartridge memories. CPU writes anywhere in the upper-middle 16 KB window ($8000-$BFFF) reach a small register file. Only the low address nibble picks the register slot, so every slot repeats throughout that window. From the stored values the block builds the program ROM address, the character ROM address and the nametable select line. It also drives the work-RAM enables for $6000-$7FFF.

Slots 0-7 and 8-9 belong to the audio and timer blocks. For those slots the block only decodes the write and raises a strobe. It does not store their contents. The program ROM window at $8000-$BFFF is switchable. The window at $C000-$FFFF is pinned to the last bank. Character memory is split into four independent 2 KB banks. Nametable mirroring has four settings: vertical, horizontal and two single-screen pages.

Top module: `cart_bank_map`

## Requirements
- R1: A write with `cpu_we_i` high and `cpu_addr_i[15:14]` = 2'b10 is stored into slot `cpu_addr_i[3:0]` at the clock edge, and address bits [13:4] do not matter. A write to any other address changes no stored value.
- R2: For CPU addresses $8000-$BFFF, `prg_addr_o` = {slot $B bank, `cpu_addr_i[13:0]`}. Only data bits [3:0] of a slot $B write are kept.
- R3: For CPU addresses $C000-$FFFF, `prg_addr_o` = {4'hF, `cpu_addr_i[13:0]`}, whatever slot $B holds.
- R4: For PPU addresses below $2000, `chr_addr_o` = {bank, `ppu_addr_i[10:0]`}. The bank comes from slot $C, $D, $E or $F when `ppu_addr_i[12:11]` is 0, 1, 2 or 3. Only data bits [3:0] are kept.
- R5: Control slot $A bits [1:0] set `nt_sel_o`. 00 gives `ppu_addr_i[10]`, 01 gives `ppu_addr_i[11]`, 10 gives constant 0 and 11 gives constant 1.
- R6: `ext_attr_en_o` equals control bit 2.
- R7: `ram_ce_o` is high exactly for CPU addresses $6000-$7FFF. `ram_we_o` is high only when `ram_ce_o`, `cpu_we_i` and control bit 3 are all high, so reads are always allowed.
- R8: While `rst_ni` is low, every bank register and the control register clear to zero. After reset the mirroring is vertical, the extended attribute table is off and RAM writes are off.
- R9: `snd_wr_o` is high for a window write to slots 0-7, and `tmr_wr_o` is high for a window write to slots 8-9. The two are never high together. `reg_idx_o` equals `cpu_addr_i[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU-side clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address bus |
| cpu_data_i | input | 8 | CPU write data |
| cpu_we_i | input | 1 | CPU write strobe |
| ppu_addr_i | input | 14 | PPU address bus |
| prg_addr_o | output | 18 | Program ROM address |
| chr_addr_o | output | 15 | Character ROM address |
| nt_sel_o | output | 1 | Nametable page select |
| ext_attr_en_o | output | 1 | Extended attribute table enable |
| ram_ce_o | output | 1 | Work RAM chip enable |
| ram_we_o | output | 1 | Work RAM write enable |
| snd_wr_o | output | 1 | Write strobe to audio slots |
| tmr_wr_o | output | 1 | Write strobe to timer slots |
| reg_idx_o | output | 4 | Slot index for the routed write |

## Verification
Directed writes use aliased addresses such as $BFFB and $A5FB. They show that only the low nibble selects a slot, and a write to $7FFB shows that addresses outside the window store nothing. All four mirroring codes are swept against PPU addresses with A10 and A11 set differently, which separates vertical from horizontal and the two single-screen pages from each other. Random traffic over the full 16-bit address space mixes register writes, RAM accesses and ROM reads. A model in the bench predicts every output, so a wrong slot decode, a swapped CHR bank or a leaking RAM enable shows up as a mismatch.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
  typedef enum logic [1:0] {
    MIR_VERT  = 2'b00,
    MIR_HORZ  = 2'b01,
    MIR_ONE_A = 2'b10,
    MIR_ONE_B = 2'b11
  } mirror_e;

  localparam logic [3:0] SLOT_CTRL = 4'hA;
  localparam logic [3:0] SLOT_PRG  = 4'hB;
  localparam logic [3:0] SLOT_CHR0 = 4'hC;
  localparam int CTRL_W      = 4;
  localparam int CTRL_EXT    = 2;
  localparam int CTRL_RAM_WE = 3;
  localparam int NUM_CHR     = 4;
endpackage

// File: rtl/cart_map_regs.sv
module cart_map_regs
  import cart_map_pkg::*;
#(
  parameter int PRG_BANK_W = 4,
  parameter int CHR_BANK_W = 4
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 wr_i,
  input  logic [3:0]                           slot_i,
  input  logic [7:0]                           data_i,
  output logic [PRG_BANK_W-1:0]                prg_bank_o,
  output logic [NUM_CHR-1:0][CHR_BANK_W-1:0]   chr_bank_o,
  output logic [CTRL_W-1:0]                    ctrl_o
);
  logic [PRG_BANK_W-1:0] prg_bank_q;
  logic [CTRL_W-1:0]     ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prg_bank_q <= '0;
      ctrl_q     <= '0;
    end else if (wr_i) begin
      if (slot_i == SLOT_PRG)  prg_bank_q <= data_i[PRG_BANK_W-1:0];
      if (slot_i == SLOT_CTRL) ctrl_q     <= data_i[CTRL_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_CHR; g++) begin : g_chr
    localparam logic [3:0] MySlot = SLOT_CHR0 + 4'(g);
    logic [CHR_BANK_W-1:0] bank_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       bank_q <= '0;
      else if (wr_i && slot_i == MySlot) bank_q <= data_i[CHR_BANK_W-1:0];
    end
    assign chr_bank_o[g] = bank_q;
  end

  assign prg_bank_o = prg_bank_q;
  assign ctrl_o     = ctrl_q;
endmodule

// File: rtl/cart_prg_map.sv
module cart_prg_map #(
  parameter int PRG_BANK_W = 4,
  parameter int PRG_PAGE_W = 14,
  localparam int PrgAddrW  = PRG_BANK_W + PRG_PAGE_W
) (
  input  logic [15:0]           cpu_addr_i,
  input  logic                  cpu_we_i,
  input  logic [PRG_BANK_W-1:0] prg_bank_i,
  input  logic                  ram_wr_en_i,
  output logic [PrgAddrW-1:0]   prg_addr_o,
  output logic                  ram_ce_o,
  output logic                  ram_we_o
);
  logic fixed_win;
  logic [PRG_BANK_W-1:0] bank_sel;

  assign fixed_win  = cpu_addr_i[15:14] == 2'b11;
  // upper window pinned to the final bank
  assign bank_sel   = fixed_win ? {PRG_BANK_W{1'b1}} : prg_bank_i;
  assign prg_addr_o = {bank_sel, cpu_addr_i[PRG_PAGE_W-1:0]};
  assign ram_ce_o   = cpu_addr_i[15:13] == 3'b011;
  assign ram_we_o   = ram_ce_o & cpu_we_i & ram_wr_en_i;
endmodule

// File: rtl/cart_chr_map.sv
module cart_chr_map
  import cart_map_pkg::*;
#(
  parameter int CHR_BANK_W = 4,
  parameter int CHR_PAGE_W = 11,
  localparam int ChrAddrW  = CHR_BANK_W + CHR_PAGE_W
) (
  input  logic [13:0]                         ppu_addr_i,
  input  logic [NUM_CHR-1:0][CHR_BANK_W-1:0]  chr_bank_i,
  input  mirror_e                             mirror_i,
  output logic [ChrAddrW-1:0]                 chr_addr_o,
  output logic                                nt_sel_o
);
  logic [1:0] quarter;
  logic       unused_ppu;

  assign quarter    = ppu_addr_i[CHR_PAGE_W+1:CHR_PAGE_W];
  assign chr_addr_o = {chr_bank_i[quarter], ppu_addr_i[CHR_PAGE_W-1:0]};
  assign unused_ppu = ppu_addr_i[13];

  always_comb begin
    unique case (mirror_i)
      MIR_VERT:  nt_sel_o = ppu_addr_i[10];
      MIR_HORZ:  nt_sel_o = ppu_addr_i[11];
      MIR_ONE_A: nt_sel_o = 1'b0;
      default:   nt_sel_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/cart_bank_map.sv
module cart_bank_map
  import cart_map_pkg::*;
#(
  parameter int PRG_BANK_W = 4,
  parameter int PRG_PAGE_W = 14,
  parameter int CHR_BANK_W = 4,
  parameter int CHR_PAGE_W = 11,
  localparam int PrgAddrW  = PRG_BANK_W + PRG_PAGE_W,
  localparam int ChrAddrW  = CHR_BANK_W + CHR_PAGE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [15:0]         cpu_addr_i,
  input  logic [7:0]          cpu_data_i,
  input  logic                cpu_we_i,
  input  logic [13:0]         ppu_addr_i,
  output logic [PrgAddrW-1:0] prg_addr_o,
  output logic [ChrAddrW-1:0] chr_addr_o,
  output logic                nt_sel_o,
  output logic                ext_attr_en_o,
  output logic                ram_ce_o,
  output logic                ram_we_o,
  output logic                snd_wr_o,
  output logic                tmr_wr_o,
  output logic [3:0]          reg_idx_o
);
  logic                               reg_wr;
  logic [PRG_BANK_W-1:0]              prg_bank_q;
  logic [NUM_CHR-1:0][CHR_BANK_W-1:0] chr_bank_q;
  logic [CTRL_W-1:0]                  ctrl_q;

  // 16 KB alias window, slot from low nibble only
  assign reg_wr    = cpu_we_i & (cpu_addr_i[15:14] == 2'b10);
  assign reg_idx_o = cpu_addr_i[3:0];
  assign snd_wr_o  = reg_wr & ~cpu_addr_i[3];
  assign tmr_wr_o  = reg_wr & (cpu_addr_i[3:1] == 3'b100);
  assign ext_attr_en_o = ctrl_q[CTRL_EXT];

  cart_map_regs #(
    .PRG_BANK_W(PRG_BANK_W),
    .CHR_BANK_W(CHR_BANK_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr),
    .slot_i     (cpu_addr_i[3:0]),
    .data_i     (cpu_data_i),
    .prg_bank_o (prg_bank_q),
    .chr_bank_o (chr_bank_q),
    .ctrl_o     (ctrl_q)
  );

  cart_prg_map #(
    .PRG_BANK_W(PRG_BANK_W),
    .PRG_PAGE_W(PRG_PAGE_W)
  ) u_prg (
    .cpu_addr_i  (cpu_addr_i),
    .cpu_we_i    (cpu_we_i),
    .prg_bank_i  (prg_bank_q),
    .ram_wr_en_i (ctrl_q[CTRL_RAM_WE]),
    .prg_addr_o  (prg_addr_o),
    .ram_ce_o    (ram_ce_o),
    .ram_we_o    (ram_we_o)
  );

  cart_chr_map #(
    .CHR_BANK_W(CHR_BANK_W),
    .CHR_PAGE_W(CHR_PAGE_W)
  ) u_chr (
    .ppu_addr_i (ppu_addr_i),
    .chr_bank_i (chr_bank_q),
    .mirror_i   (mirror_e'(ctrl_q[1:0])),
    .chr_addr_o (chr_addr_o),
    .nt_sel_o   (nt_sel_o)
  );
endmodule

// File: rtl/cart_bank_map_chk.sv
module cart_bank_map_chk #(
  parameter int PRG_BANK_W = 4,
  parameter int PRG_PAGE_W = 14
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [15:0]                    cpu_addr_i,
  input logic [7:0]                     cpu_data_i,
  input logic                           cpu_we_i,
  input logic [13:0]                    ppu_addr_i,
  input logic [PRG_BANK_W+PRG_PAGE_W-1:0] prg_addr_o,
  input logic                           nt_sel_o,
  input logic                           ram_ce_o,
  input logic                           ram_we_o,
  input logic                           snd_wr_o,
  input logic                           tmr_wr_o,
  input logic [PRG_BANK_W-1:0]          prg_bank_q,
  input logic [3:0]                     ctrl_q
);
  logic win_wr;
  assign win_wr = cpu_we_i && cpu_addr_i[15:14] == 2'b10;

  AST_PRG_SLOT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_wr && cpu_addr_i[3:0] == 4'hB) |=> prg_bank_q == $past(cpu_data_i[PRG_BANK_W-1:0])); // R1
  AST_NO_STRAY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_wr |=> ($stable(ctrl_q) && $stable(prg_bank_q))); // R1
  AST_FIXED_LAST_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_addr_i[15:14] == 2'b11 |-> prg_addr_o[PRG_BANK_W+PRG_PAGE_W-1:PRG_PAGE_W] == '1); // R3
  AST_SINGLE_SCREEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[1] |-> nt_sel_o == ctrl_q[0]); // R5
  AST_RAM_WE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_ce_o && cpu_we_i && ctrl_q[3])); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({snd_wr_o, tmr_wr_o}) <= 1); // R9
  AST_STROBE_NEEDS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snd_wr_o || tmr_wr_o) |-> win_wr); // R9
endmodule

bind cart_bank_map cart_bank_map_chk #(
  .PRG_BANK_W(PRG_BANK_W),
  .PRG_PAGE_W(PRG_PAGE_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_addr_i (cpu_addr_i),
  .cpu_data_i (cpu_data_i),
  .cpu_we_i   (cpu_we_i),
  .ppu_addr_i (ppu_addr_i),
  .prg_addr_o (prg_addr_o),
  .nt_sel_o   (nt_sel_o),
  .ram_ce_o   (ram_ce_o),
  .ram_we_o   (ram_we_o),
  .snd_wr_o   (snd_wr_o),
  .tmr_wr_o   (tmr_wr_o),
  .prg_bank_q (prg_bank_q),
  .ctrl_q     (ctrl_q)
);

// File: tb/cart_bank_map_tb.sv
`timescale 1ns/1ps
module cart_bank_map_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_we = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic [17:0] prg_addr;
  logic [14:0] chr_addr;
  logic        nt_sel, ext_en, ram_ce, ram_we, snd_wr, tmr_wr;
  logic [3:0]  reg_idx;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [3:0] m_prg, m_ctrl;
  logic [3:0] m_chr [4];

  always #2.5 clk = ~clk;

  cart_bank_map u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(cpu_addr), .cpu_data_i(cpu_data),
    .cpu_we_i(cpu_we), .ppu_addr_i(ppu_addr), .prg_addr_o(prg_addr),
    .chr_addr_o(chr_addr), .nt_sel_o(nt_sel), .ext_attr_en_o(ext_en),
    .ram_ce_o(ram_ce), .ram_we_o(ram_we), .snd_wr_o(snd_wr),
    .tmr_wr_o(tmr_wr), .reg_idx_o(reg_idx)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] exp_prg(logic [15:0] a);
    return {(a[14] ? 4'hF : m_prg), a[13:0]};
  endfunction

  function automatic logic [14:0] exp_chr(logic [13:0] p);
    return {m_chr[p[12:11]], p[10:0]};
  endfunction

  function automatic logic exp_nt(logic [13:0] p);
    case (m_ctrl[1:0])
      2'b00: return p[10];
      2'b01: return p[11];
      2'b10: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  // one bus cycle: drive, check every output, clock, update model
  task automatic cyc(logic [15:0] a, logic [7:0] d, logic we, logic [13:0] p);
    logic win, rce;
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_we = we; ppu_addr = p;
    #1;
    win = we && a[15:14] == 2'b10;
    rce = a[15:13] == 3'b011;
    if (a[15]) chk(a[14] ? "R3 prg fixed" : "R2 prg bank", 32'(prg_addr), 32'(exp_prg(a)));
    if (!p[13]) chk("R4 chr", 32'(chr_addr), 32'(exp_chr(p)));
    chk("R5 nt_sel", 32'(nt_sel), 32'(exp_nt(p)));
    chk("R6 ext_attr", 32'(ext_en), 32'(m_ctrl[2]));
    chk("R7 ram_ce", 32'(ram_ce), 32'(rce));
    chk("R7 ram_we", 32'(ram_we), 32'(rce && we && m_ctrl[3]));
    chk("R9 snd_wr", 32'(snd_wr), 32'(win && !a[3]));
    chk("R9 tmr_wr", 32'(tmr_wr), 32'(win && a[3:1] == 3'b100));
    chk("R9 reg_idx", 32'(reg_idx), 32'(a[3:0]));
    @(posedge clk);
    if (win) begin
      case (a[3:0])
        4'hA: m_ctrl = d[3:0];
        4'hB: m_prg = d[3:0];
        4'hC, 4'hD, 4'hE, 4'hF: m_chr[a[1:0]] = d[3:0];
        default: ;
      endcase
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    m_prg = '0; m_ctrl = '0;
    for (int i = 0; i < 4; i++) m_chr[i] = '0;
    #12;
    // R8 reset state
    chk("R8 prg reset", 32'(prg_addr), 32'h0);
    chk("R8 chr reset", 32'(chr_addr), 32'h0);
    chk("R8 ext reset", 32'(ext_en), 32'h0);
    rst_n = 1'b1;
    cyc(16'h8123, 8'h00, 1'b0, 14'h0400);
    cyc(16'h6000, 8'h00, 1'b1, 14'h0000);  // R8 RAM writes off after reset

    // R1 aliased slot writes, stray write ignored
    cyc(16'hBFFB, 8'hF5, 1'b1, 14'h0000);
    cyc(16'h8000, 8'h00, 1'b0, 14'h0000);
    chk("R1 alias BFFB", 32'(prg_addr[17:14]), 32'h5);
    cyc(16'h7FFB, 8'h09, 1'b1, 14'h0000);
    cyc(16'h9ABC, 8'h00, 1'b0, 14'h0000);
    chk("R1 outside ignored", 32'(prg_addr[17:14]), 32'h5);
    cyc(16'hA5FB, 8'h0C, 1'b1, 14'h0000);
    cyc(16'hC000, 8'h00, 1'b0, 14'h0000);
    cyc(16'h8001, 8'h00, 1'b0, 14'h0000);
    chk("R1 alias A5FB", 32'(prg_addr[17:14]), 32'hC);

    // R4 four CHR banks
    cyc(16'h800C, 8'h31, 1'b1, 14'h0000);
    cyc(16'h801D, 8'h42, 1'b1, 14'h0000);
    cyc(16'h802E, 8'h53, 1'b1, 14'h0000);
    cyc(16'h803F, 8'hF4, 1'b1, 14'h0000);
    for (int q = 0; q < 4; q++) cyc(16'h0000, 8'h00, 1'b0, 14'(q * 14'h0800 + 14'h123));

    // R5 R6 R7 all control codes against A10/A11 patterns
    for (int c = 0; c < 16; c++) begin
      cyc(16'h800A, 8'(c) | 8'hF0, 1'b1, 14'h0000);
      cyc(16'h2400, 8'h00, 1'b0, 14'h2400);
      cyc(16'h2800, 8'h00, 1'b0, 14'h2800);
      cyc(16'h7ABC, 8'h00, 1'b1, 14'h2C00);
    end

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if ($urandom_range(0, 3) == 0) a[15:14] = 2'b10;
      cyc(a, 8'($urandom), 1'($urandom), 14'($urandom));
    end

    cyc(16'h0000, 8'h00, 1'b0, 14'h0000);
    finish_run();
  end
endmodule